// File: doc/BRIEF.md
# Execution-Context Access Controller

This block sits between the memory bus of a small processor core and the on-chip targets behind it. It keeps a single mode bit, firmware or application. The mode is not written by software. It is set in hardware the first time an instruction is fetched from outside the firmware ROM window. After that, the mode stays in application until the next reset.

Every bus request is checked against the address window it falls in. The check combines the current mode with two context inputs. One marks that the low-priority syscall interrupt is being serviced, and the other marks the high-priority one. A request that passes is forwarded unchanged to the target port. A request that fails gets a local reply instead: it is accepted at once, it returns zero data, any write is dropped, and the trap output is raised during that same cycle.

Three dedicated addresses are answered locally and never forwarded. A data write to either of the two interrupt addresses produces a one-cycle request pulse for that interrupt source. A data write to the reset address produces a one-cycle system-reset request. The block also drives three permission levels, one for each protected target: ROM execution, the firmware RAM and the SPI master.

Top module: `exec_guard`

## Requirements
- R1: After reset, `app_mode`, `trap`, `irq_trig` and `sys_reset_req` are all 0, so the block starts in firmware mode.
- R2: `app_mode` becomes 1 on the clock edge that accepts an instruction fetch (`req_valid`, `req_ready` and `req_fetch` all high) to an address outside the ROM window. Once set, it stays 1 until reset. A fetch that is not accepted because `tgt_ready` is low leaves the mode unchanged.
- R3: A fetch from the ROM window is forwarded only when `app_mode` is 0, `ctx_lo` is 1 or `ctx_hi` is 1. Otherwise it is denied. Data reads and data writes to the ROM window are always forwarded.
- R4: Any access to the firmware RAM window is forwarded only when `app_mode` is 0 or `ctx_hi` is 1, and is denied otherwise. `fwram_en` equals this permission level.
- R5: Any access to the SPI master window is denied while `app_mode` is 1. `spi_en` is 1 exactly when `app_mode` is 0.
- R6: A denied request gives all of the following in the same cycle: `req_ready` is 1, `req_rdata` is 0, `tgt_valid` is 0 and `trap` is 1. `trap` is 0 in every cycle without a denied request.
- R7: A permitted request outside the three trigger addresses is passed straight through. `tgt_valid` follows `req_valid`, and `tgt_addr`, `tgt_write` and `tgt_wdata` follow the request. `req_ready` follows `tgt_ready`, and `req_rdata` follows `tgt_rdata`.
- R8: A data write to `IRQ0_ADDR` or `IRQ1_ADDR` drives `irq_trig` bit 0 or bit 1, respectively, high for exactly one cycle after the accepting edge (with the default `REG_TRIG=1`). A read of these addresses returns 0 and makes no pulse. An access to them is never forwarded.
- R9: A data write to `RST_ADDR` drives `sys_reset_req` high for exactly one cycle after the accepting edge (with `REG_TRIG=1`). The access is never forwarded.
- R10: `rom_exec_ok` is 1 exactly when `app_mode` is 0, `ctx_lo` is 1 or `ctx_hi` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_lo | input | 1 | Low-priority syscall interrupt is being serviced |
| ctx_hi | input | 1 | High-priority syscall interrupt is being serviced |
| req_valid | input | 1 | Request from the core is valid |
| req_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| req_write | input | 1 | Data write when 1 |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted in this cycle |
| req_rdata | output | DW | Read data returned to the core |
| tgt_valid | output | 1 | Request forwarded to the targets |
| tgt_write | output | 1 | Forwarded write flag |
| tgt_addr | output | AW | Forwarded address |
| tgt_wdata | output | DW | Forwarded write data |
| tgt_ready | input | 1 | Target accepts the forwarded request |
| tgt_rdata | input | DW | Target read data |
| rom_exec_ok | output | 1 | ROM execution permitted |
| fwram_en | output | 1 | Firmware RAM access permitted |
| spi_en | output | 1 | SPI master access permitted |
| app_mode | output | 1 | 1 in application mode |
| trap | output | 1 | Denied request in this cycle |
| irq_trig | output | 2 | Interrupt request pulses, bit n for source n |
| sys_reset_req | output | 1 | System reset request pulse |

## Verification
The assertions check on every cycle the following:
- the application mode never reverts to firmware mode;
- the transition to application mode follows an accepted outside fetch;
- each forbidden combination of window, mode and context produces a trap with no forwarding;
- the local reply to a denied request;
- the trigger pulses that follow writes to the trigger addresses.

Other behaviour can only be shown by the bench's scenarios:
- the return to firmware mode through reset;
- a stalled fetch that leaves the mode unchanged;
- the pass-through of data from the targets;
- a pulse that lasts exactly one cycle;
- the full sweep over the four context combinations in each mode.

// File: rtl/egd_pkg.sv
package egd_pkg;
   // Index of each address class in the decoder's one-hot hit vector
   localparam int IX_ROM   = 0;
   localparam int IX_FWRAM = 1;
   localparam int IX_SPI   = 2;
   localparam int NWIN     = 3;
   localparam int IX_IRQ0  = NWIN + 0;
   localparam int IX_IRQ1  = NWIN + 1;
   localparam int IX_RST   = NWIN + 2;
   localparam int NTRIG    = 3;
   localparam int IX_OPEN  = NWIN + NTRIG;
   localparam int NREG     = NWIN + NTRIG + 1;

   typedef struct packed {
      logic deny;
      logic local_sel;
      logic rom_exec_ok;
      logic fwram_ok;
      logic spi_ok;
   } verdict_t;
endpackage

// File: rtl/egd_decode.sv
module egd_decode
   import egd_pkg::*;
#(
   parameter int AW = 16,
   parameter logic [AW-1:0] ROM_BASE   = 16'h0000,
   parameter logic [AW-1:0] ROM_SIZE   = 16'h1000,
   parameter logic [AW-1:0] FWRAM_BASE = 16'h2000,
   parameter logic [AW-1:0] FWRAM_SIZE = 16'h0400,
   parameter logic [AW-1:0] SPI_BASE   = 16'h3000,
   parameter logic [AW-1:0] SPI_SIZE   = 16'h0100,
   parameter logic [AW-1:0] IRQ0_ADDR  = 16'h3F00,
   parameter logic [AW-1:0] IRQ1_ADDR  = 16'h3F04,
   parameter logic [AW-1:0] RST_ADDR   = 16'h3F08
) (
   input  logic [AW-1:0]   addr,
   output logic [NREG-1:0] hit
);
   localparam logic [AW-1:0] WBASE [NWIN]  = '{ROM_BASE, FWRAM_BASE, SPI_BASE};
   localparam logic [AW-1:0] WSIZE [NWIN]  = '{ROM_SIZE, FWRAM_SIZE, SPI_SIZE};
   localparam logic [AW-1:0] TADDR [NTRIG] = '{IRQ0_ADDR, IRQ1_ADDR, RST_ADDR};

   logic [NWIN+NTRIG-1:0] any;

   // Elaboration-time checks on the address map
   for (genvar i = 0; i < NWIN; i++) begin : g_wchk
      if (WSIZE[i] == '0) begin : g_zero
         $error("egd_decode: window %0d has zero size", i);
      end
      if ({1'b0, WBASE[i]} + {1'b0, WSIZE[i]} > (1 << AW)) begin : g_wrap
         $error("egd_decode: window %0d runs past the address space", i);
      end
      for (genvar j = i + 1; j < NWIN; j++) begin : g_ovl
         if (({1'b0, WBASE[i]} < {1'b0, WBASE[j]} + {1'b0, WSIZE[j]}) &&
             ({1'b0, WBASE[j]} < {1'b0, WBASE[i]} + {1'b0, WSIZE[i]})) begin : g_bad
            $error("egd_decode: windows %0d and %0d overlap", i, j);
         end
      end
      for (genvar t = 0; t < NTRIG; t++) begin : g_tin
         if ((TADDR[t] >= WBASE[i]) &&
             ({1'b0, TADDR[t]} < {1'b0, WBASE[i]} + {1'b0, WSIZE[i]})) begin : g_bad
            $error("egd_decode: trigger %0d lies inside window %0d", t, i);
         end
      end
   end
   for (genvar t = 0; t < NTRIG; t++) begin : g_tchk
      for (genvar u = t + 1; u < NTRIG; u++) begin : g_dup
         if (TADDR[t] == TADDR[u]) begin : g_bad
            $error("egd_decode: triggers %0d and %0d share an address", t, u);
         end
      end
   end

   // Range windows
   for (genvar i = 0; i < NWIN; i++) begin : g_win
      logic [AW:0] lim;
      assign lim = {1'b0, WBASE[i]} + {1'b0, WSIZE[i]};
      assign any[i] = (addr >= WBASE[i]) && ({1'b0, addr} < lim);
   end

   // Single-address triggers
   for (genvar t = 0; t < NTRIG; t++) begin : g_trg
      assign any[NWIN+t] = (addr == TADDR[t]);
   end

   assign hit = {~|any, any};
endmodule

// File: rtl/egd_mode.sv
module egd_mode (
   input  logic clk,
   input  logic rst_n,
   input  logic fetch_accept,
   input  logic fetch_in_rom,
   output logic app_mode
);
   // One-way latch: firmware -> application, cleared only by reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         app_mode <= 1'b0;
      end else if (fetch_accept && !fetch_in_rom) begin
         app_mode <= 1'b1;
      end
   end
endmodule

// File: rtl/egd_policy.sv
module egd_policy
   import egd_pkg::*;
(
   input  logic [NREG-1:0] hit,
   input  logic            fetch,
   input  logic            app_mode,
   input  logic            ctx_lo,
   input  logic            ctx_hi,
   output verdict_t        verdict
);
   logic exec_ok, ram_ok, spi_ok;

   assign exec_ok = !app_mode || ctx_lo || ctx_hi;
   assign ram_ok  = !app_mode || ctx_hi;
   assign spi_ok  = !app_mode;

   always_comb begin
      verdict             = '0;
      verdict.rom_exec_ok = exec_ok;
      verdict.fwram_ok    = ram_ok;
      verdict.spi_ok      = spi_ok;
      verdict.local_sel   = |hit[IX_RST:IX_IRQ0];
      verdict.deny        = (hit[IX_ROM] && fetch && !exec_ok) ||
                            (hit[IX_FWRAM] && !ram_ok) ||
                            (hit[IX_SPI] && !spi_ok);
   end
endmodule

// File: rtl/egd_trigger.sv
module egd_trigger
   import egd_pkg::*;
#(
   parameter bit REG_TRIG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_accept,
   input  logic [NREG-1:0] hit,
   output logic [1:0]      irq_trig,
   output logic            sys_reset_req
);
   logic [NTRIG-1:0] fire;

   assign fire = wr_accept ? hit[IX_RST:IX_IRQ0] : '0;

   if (REG_TRIG) begin : g_reg
      logic [NTRIG-1:0] fire_q;
      always_ff @(posedge clk) begin
         if (!rst_n) fire_q <= '0;
         else        fire_q <= fire;
      end
      assign irq_trig      = fire_q[1:0];
      assign sys_reset_req = fire_q[2];
   end else begin : g_comb
      assign irq_trig      = fire[1:0];
      assign sys_reset_req = fire[2];
   end
endmodule

// File: rtl/exec_guard.sv
module exec_guard
   import egd_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter logic [AW-1:0] ROM_BASE   = 16'h0000,
   parameter logic [AW-1:0] ROM_SIZE   = 16'h1000,
   parameter logic [AW-1:0] FWRAM_BASE = 16'h2000,
   parameter logic [AW-1:0] FWRAM_SIZE = 16'h0400,
   parameter logic [AW-1:0] SPI_BASE   = 16'h3000,
   parameter logic [AW-1:0] SPI_SIZE   = 16'h0100,
   parameter logic [AW-1:0] IRQ0_ADDR  = 16'h3F00,
   parameter logic [AW-1:0] IRQ1_ADDR  = 16'h3F04,
   parameter logic [AW-1:0] RST_ADDR   = 16'h3F08,
   parameter bit REG_TRIG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctx_lo,
   input  logic          ctx_hi,
   input  logic          req_valid,
   input  logic          req_fetch,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic [DW-1:0] req_rdata,
   output logic          tgt_valid,
   output logic          tgt_write,
   output logic [AW-1:0] tgt_addr,
   output logic [DW-1:0] tgt_wdata,
   input  logic          tgt_ready,
   input  logic [DW-1:0] tgt_rdata,
   output logic          rom_exec_ok,
   output logic          fwram_en,
   output logic          spi_en,
   output logic          app_mode,
   output logic          trap,
   output logic [1:0]    irq_trig,
   output logic          sys_reset_req
);
   if (AW < 4) begin : g_aw_chk
      $error("exec_guard: AW must be at least 4");
   end
   if (DW < 8) begin : g_dw_chk
      $error("exec_guard: DW must be at least 8");
   end

   logic [NREG-1:0] hit;
   verdict_t        verdict;
   logic            answer_here;
   logic            accept;

   egd_decode #(
      .AW(AW),
      .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE),
      .FWRAM_BASE(FWRAM_BASE), .FWRAM_SIZE(FWRAM_SIZE),
      .SPI_BASE(SPI_BASE), .SPI_SIZE(SPI_SIZE),
      .IRQ0_ADDR(IRQ0_ADDR), .IRQ1_ADDR(IRQ1_ADDR), .RST_ADDR(RST_ADDR)
   ) u_decode (
      .addr (req_addr),
      .hit  (hit)
   );

   egd_policy u_policy (
      .hit      (hit),
      .fetch    (req_fetch),
      .app_mode (app_mode),
      .ctx_lo   (ctx_lo),
      .ctx_hi   (ctx_hi),
      .verdict  (verdict)
   );

   assign answer_here = verdict.deny || verdict.local_sel;

   assign tgt_valid = req_valid && !answer_here;
   assign tgt_write = req_write;
   assign tgt_addr  = req_addr;
   assign tgt_wdata = req_wdata;
   assign req_ready = answer_here ? 1'b1 : tgt_ready;
   assign req_rdata = answer_here ? '0 : tgt_rdata;
   assign trap      = req_valid && verdict.deny;
   assign accept    = req_valid && req_ready;

   assign rom_exec_ok = verdict.rom_exec_ok;
   assign fwram_en    = verdict.fwram_ok;
   assign spi_en      = verdict.spi_ok;

   egd_mode u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .fetch_accept (accept && req_fetch),
      .fetch_in_rom (hit[IX_ROM]),
      .app_mode     (app_mode)
   );

   egd_trigger #(.REG_TRIG(REG_TRIG)) u_trigger (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_accept     (accept && req_write && !req_fetch),
      .hit           (hit),
      .irq_trig      (irq_trig),
      .sys_reset_req (sys_reset_req)
   );
endmodule

// File: rtl/egd_checker.sv
module egd_checker #(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter logic [AW-1:0] ROM_BASE   = 16'h0000,
   parameter logic [AW-1:0] ROM_SIZE   = 16'h1000,
   parameter logic [AW-1:0] FWRAM_BASE = 16'h2000,
   parameter logic [AW-1:0] FWRAM_SIZE = 16'h0400,
   parameter logic [AW-1:0] SPI_BASE   = 16'h3000,
   parameter logic [AW-1:0] SPI_SIZE   = 16'h0100,
   parameter logic [AW-1:0] IRQ0_ADDR  = 16'h3F00,
   parameter logic [AW-1:0] IRQ1_ADDR  = 16'h3F04,
   parameter logic [AW-1:0] RST_ADDR   = 16'h3F08,
   parameter bit REG_TRIG = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctx_lo,
   input logic          ctx_hi,
   input logic          req_valid,
   input logic          req_fetch,
   input logic          req_write,
   input logic [AW-1:0] req_addr,
   input logic          req_ready,
   input logic [DW-1:0] req_rdata,
   input logic          tgt_valid,
   input logic          app_mode,
   input logic          trap,
   input logic [1:0]    irq_trig,
   input logic          sys_reset_req
);
   logic in_rom, in_ram, in_spi, wr_data;

   assign in_rom  = ({1'b0, req_addr} >= {1'b0, ROM_BASE}) &&
                    ({1'b0, req_addr} <  {1'b0, ROM_BASE} + {1'b0, ROM_SIZE});
   assign in_ram  = ({1'b0, req_addr} >= {1'b0, FWRAM_BASE}) &&
                    ({1'b0, req_addr} <  {1'b0, FWRAM_BASE} + {1'b0, FWRAM_SIZE});
   assign in_spi  = ({1'b0, req_addr} >= {1'b0, SPI_BASE}) &&
                    ({1'b0, req_addr} <  {1'b0, SPI_BASE} + {1'b0, SPI_SIZE});
   assign wr_data = req_valid && req_ready && req_write && !req_fetch;

   p_mode_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      app_mode |=> app_mode);

   p_mode_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_fetch && !in_rom) |=> app_mode);

   p_rom_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_fetch && in_rom && app_mode && !ctx_lo && !ctx_hi)
      |-> (trap && !tgt_valid));

   p_fwram_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && in_ram && app_mode && !ctx_hi) |-> (trap && !tgt_valid));

   p_spi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && in_spi && app_mode) |-> (trap && !tgt_valid));

   p_deny_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> (req_ready && (req_rdata == '0) && !tgt_valid));

   p_trig_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_trig, sys_reset_req}));

   if (REG_TRIG) begin : g_reg
      p_irq0_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_data && req_addr == IRQ0_ADDR) |=> irq_trig[0]);
      p_irq1_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_data && req_addr == IRQ1_ADDR) |=> irq_trig[1]);
      p_sysrst_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_data && req_addr == RST_ADDR) |=> sys_reset_req);
   end else begin : g_comb
      p_irq0_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_data && req_addr == IRQ0_ADDR) |-> irq_trig[0]);
      p_irq1_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_data && req_addr == IRQ1_ADDR) |-> irq_trig[1]);
      p_sysrst_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_data && req_addr == RST_ADDR) |-> sys_reset_req);
   end
endmodule

bind exec_guard egd_checker #(
   .AW(AW), .DW(DW),
   .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE),
   .FWRAM_BASE(FWRAM_BASE), .FWRAM_SIZE(FWRAM_SIZE),
   .SPI_BASE(SPI_BASE), .SPI_SIZE(SPI_SIZE),
   .IRQ0_ADDR(IRQ0_ADDR), .IRQ1_ADDR(IRQ1_ADDR), .RST_ADDR(RST_ADDR),
   .REG_TRIG(REG_TRIG)
) u_egd_checker (.*);

// File: tb/exec_guard_bench.sv
module exec_guard_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 32;

   // Bench's own view of the default address map
   localparam logic [AW-1:0] A_ROM  = 16'h0010;
   localparam logic [AW-1:0] A_ROME = 16'h0FFF;
   localparam logic [AW-1:0] A_RAM  = 16'h2010;
   localparam logic [AW-1:0] A_SPI  = 16'h3004;
   localparam logic [AW-1:0] A_OPEN = 16'h8000;
   localparam logic [AW-1:0] A_IRQ0 = 16'h3F00;
   localparam logic [AW-1:0] A_IRQ1 = 16'h3F04;
   localparam logic [AW-1:0] A_RST  = 16'h3F08;

   // Region codes used by the bench
   localparam int RC_ROM = 0, RC_RAM = 1, RC_SPI = 2, RC_OPEN = 3,
                  RC_IRQ0 = 4, RC_IRQ1 = 5, RC_RST = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctx_lo = 1'b0, ctx_hi = 1'b0;
   logic req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready;
   logic [DW-1:0] req_rdata;
   logic tgt_valid, tgt_write;
   logic [AW-1:0] tgt_addr;
   logic [DW-1:0] tgt_wdata;
   logic tgt_ready = 1'b1;
   logic [DW-1:0] tgt_rdata;
   logic rom_exec_ok, fwram_en, spi_en, app_mode, trap, sys_reset_req;
   logic [1:0] irq_trig;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   assign tgt_rdata = {16'hC3C3, tgt_addr};

   always #(CLK_PERIOD/2) clk = ~clk;

   exec_guard u_exec_guard (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] addr_of(input int rc);
      case (rc)
         RC_ROM:  return A_ROM;
         RC_RAM:  return A_RAM;
         RC_SPI:  return A_SPI;
         RC_IRQ0: return A_IRQ0;
         RC_IRQ1: return A_IRQ1;
         RC_RST:  return A_RST;
         default: return A_OPEN;
      endcase
   endfunction

   // Expected permission from the requirements (R3, R4, R5)
   function automatic bit allowed(input int rc, input bit f, input bit app,
                                  input bit lo, input bit hi);
      case (rc)
         RC_ROM:  return f ? (!app || lo || hi) : 1'b1;
         RC_RAM:  return !app || hi;
         RC_SPI:  return !app;
         default: return 1'b1;
      endcase
   endfunction

   task automatic access(input int rc, input logic [AW-1:0] a, input bit f,
                         input bit w, input bit app);
      bit ok, loc;
      logic [DW-1:0] exp_rd;
      logic [1:0] exp_irq;
      @(negedge clk);
      req_valid = 1'b1; req_fetch = f; req_write = w;
      req_addr = a; req_wdata = {16'h5A5A, a};
      #1;
      ok  = allowed(rc, f, app, ctx_lo, ctx_hi);
      loc = (rc >= RC_IRQ0);
      if (!ok) begin
         chk(trap == 1'b1, "R6", "trap on denied", DW'(trap), 1);
         chk(req_ready == 1'b1 && tgt_valid == 1'b0, "R6", "local accept",
             DW'({req_ready, tgt_valid}), 2);
         chk(req_rdata == '0, "R6", "zero read data", req_rdata, 0);
      end else if (loc) begin
         chk(trap == 1'b0, "R8", "no trap at trigger", DW'(trap), 0);
         chk(req_ready == 1'b1 && tgt_valid == 1'b0 && req_rdata == '0, "R8",
             "trigger answered locally", DW'({req_ready, tgt_valid}), 2);
      end else begin
         exp_rd = {16'hC3C3, a};
         chk(trap == 1'b0, "R7", "no trap when permitted", DW'(trap), 0);
         chk(tgt_valid == 1'b1 && tgt_addr == a && tgt_write == w &&
             tgt_wdata == {16'h5A5A, a}, "R7", "forwarded request",
             DW'(tgt_addr), DW'(a));
         chk(req_ready == tgt_ready && req_rdata == exp_rd, "R7",
             "read data passthrough", req_rdata, exp_rd);
      end
      @(negedge clk);
      req_valid = 1'b0; req_fetch = 1'b0; req_write = 1'b0;
      #1;
      exp_irq = {(rc == RC_IRQ1) && w && !f, (rc == RC_IRQ0) && w && !f};
      chk(irq_trig == exp_irq, "R8", "interrupt pulse", DW'(irq_trig), DW'(exp_irq));
      chk(sys_reset_req == ((rc == RC_RST) && w && !f), "R9", "reset pulse",
          DW'(sys_reset_req), DW'((rc == RC_RST) && w && !f));
      chk(trap == 1'b0, "R6", "trap gone after access", DW'(trap), 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(app_mode == 1'b0, "R1", "mode after reset", DW'(app_mode), 0);
      chk(trap == 1'b0 && irq_trig == 2'b00 && sys_reset_req == 1'b0, "R1",
          "quiet outputs after reset", DW'({trap, irq_trig, sys_reset_req}), 0);
   endtask

   task automatic check_levels(input bit app);
      chk(rom_exec_ok == (!app || ctx_lo || ctx_hi), "R10", "rom_exec_ok",
          DW'(rom_exec_ok), DW'(!app || ctx_lo || ctx_hi));
      chk(fwram_en == (!app || ctx_hi), "R4", "fwram_en",
          DW'(fwram_en), DW'(!app || ctx_hi));
      chk(spi_en == !app, "R5", "spi_en", DW'(spi_en), DW'(!app));
   endtask

   initial begin
      do_reset();

      // Firmware mode: every data access and every ROM fetch is permitted
      for (int c = 0; c < 4; c++) begin
         ctx_lo = c[0]; ctx_hi = c[1];
         #1 check_levels(1'b0);
         access(RC_ROM, A_ROM, 1'b1, 1'b0, 1'b0);
         access(RC_ROM, A_ROME, 1'b1, 1'b0, 1'b0);
         for (int r = RC_ROM; r <= RC_OPEN; r++) begin
            access(r, addr_of(r), 1'b0, 1'b0, 1'b0);
            access(r, addr_of(r), 1'b0, 1'b1, 1'b0);
         end
      end
      ctx_lo = 1'b0; ctx_hi = 1'b0;
      #1 chk(app_mode == 1'b0, "R2", "ROM fetch keeps firmware mode", DW'(app_mode), 0);

      // Trigger addresses: writes pulse, reads do not (R8, R9)
      for (int r = RC_IRQ0; r <= RC_RST; r++) begin
         access(r, addr_of(r), 1'b0, 1'b1, 1'b0);
         access(r, addr_of(r), 1'b0, 1'b0, 1'b0);
      end
      chk(app_mode == 1'b0, "R2", "trigger data access keeps mode", DW'(app_mode), 0);

      // Stalled outside fetch must not change the mode (R2)
      tgt_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_fetch = 1'b1; req_addr = A_OPEN;
      #1 chk(req_ready == 1'b0, "R7", "ready follows target", DW'(req_ready), 0);
      @(negedge clk);
      req_valid = 1'b0; req_fetch = 1'b0;
      #1 chk(app_mode == 1'b0, "R2", "stalled fetch keeps mode", DW'(app_mode), 0);
      tgt_ready = 1'b1;

      // Accepted outside fetch enters application mode (R2)
      access(RC_OPEN, A_OPEN, 1'b1, 1'b0, 1'b0);
      chk(app_mode == 1'b1, "R2", "outside fetch enters app mode", DW'(app_mode), 1);

      // Application mode sweep over all context combinations
      for (int c = 0; c < 4; c++) begin
         ctx_lo = c[0]; ctx_hi = c[1];
         #1 check_levels(1'b1);
         access(RC_ROM, A_ROM, 1'b1, 1'b0, 1'b1);
         access(RC_ROM, A_ROME, 1'b1, 1'b0, 1'b1);
         access(RC_RAM, A_RAM, 1'b1, 1'b0, 1'b1);
         access(RC_OPEN, A_OPEN, 1'b1, 1'b0, 1'b1);
         for (int r = RC_ROM; r <= RC_RST; r++) begin
            access(r, addr_of(r), 1'b0, 1'b0, 1'b1);
            access(r, addr_of(r), 1'b0, 1'b1, 1'b1);
         end
         chk(app_mode == 1'b1, "R2", "app mode sticks", DW'(app_mode), 1);
      end
      ctx_lo = 1'b0; ctx_hi = 1'b0;

      // Only reset returns to firmware mode (R1)
      do_reset();
      access(RC_SPI, A_SPI, 1'b0, 1'b0, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule